// File: doc/BRIEF.md
# Frame Swap Status Marker Selector

This block drives a single status pin for a video output port. A static mode setting chooses what the pin carries. In the default mode, the pin flags the one video frame that follows a framebuffer swap. It does this by gating the data-request window enable with a frame-long flag that a swap request arms. The other modes copy one raster event strobe to the pin: line start, field start, frame start, tri-level sync, or the plain data-request window. Two further modes hold the pin constantly low or constantly high.

A swap request can arrive at any point in the raster. It is held in a pending latch. At the next frame start the pending latch moves into the frame flag, and the flag drops at the frame start after that unless a further swap was pending. All inputs share the pixel clock. The raster strobes are single-cycle pulses produced elsewhere. The output comes from a register, so it changes only on a clock edge. A mode change shows on the pin after the next edge, with no glitch.

Top module: `swap_marker_top`

## Requirements
- R1: While reset (`rst_n` low) is held, `marker` is 0. Reset clears the pending swap latch and the frame flag, so no frame is flagged until a swap request has been seen.
- R2: `mode_sel` is 3 bits wide. When it is 0 (swap-qualified), `marker` one clock later equals `win_en` ANDed with the frame flag as it stood in the sampling cycle.
- R3: A `swap_req` pulse that is not coincident with `frame_start` sets the frame flag at the next `frame_start` edge. The flag is cleared at the following `frame_start` if no other swap is pending, so exactly one frame is flagged.
- R4: A `swap_req` that arrives while a frame is flagged is held and flags the next frame as well. A `swap_req` in the same cycle as `frame_start` does not flag the frame beginning at that strobe; it flags the frame that starts at the following `frame_start`.
- R5: Modes 1, 2, 3 and 4 copy `line_start`, `field_start`, `frame_start` and `trisync` respectively to `marker`, delayed by one clock.
- R6: Mode 5 copies `win_en` to `marker`, delayed by one clock and with no swap qualification.
- R7: Mode 6 drives `marker` to 0 and mode 7 drives it to 1 from the clock after selection, whatever the other inputs do.
- R8: `marker` changes only at a rising clock edge. A new `mode_sel` value sets the value taken at the very next edge.
- R9: Several `swap_req` pulses inside one frame flag only one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Source select: 0 swap-qualified, 1 line, 2 field, 3 frame, 4 tri-sync, 5 window, 6 low, 7 high |
| line_start | input | 1 | One-cycle line start strobe |
| field_start | input | 1 | One-cycle field start strobe |
| frame_start | input | 1 | One-cycle frame start strobe |
| trisync | input | 1 | Tri-level sync pulse |
| win_en | input | 1 | Data-request window enable |
| swap_req | input | 1 | Framebuffer swap pulse, unrelated in phase to the raster |
| marker | output | 1 | Registered status output |

## Verification
A compact synthetic raster is used: 8 pixels per line and 4 lines per frame. It carries fixed line, field, frame, tri-sync and window patterns, so that every source has a distinct shape. The swap-qualified mode is tested over ten frames with scripted swap pulses: a single swap mid-frame, a swap inside an already flagged frame, a swap coincident with frame start, and two swaps in one frame. Each of these separates latch-and-transfer timing from simpler schemes. Each other mode is then swept for two frames. A final phase changes the mode every cycle from a pseudo-random sequence, which exposes any select path that is not registered or lags by a cycle.

// File: rtl/swap_marker_pkg.sv
package swap_marker_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MK_SWAP  = 3'd0,
    MK_LINE  = 3'd1,
    MK_FIELD = 3'd2,
    MK_FRAME = 3'd3,
    MK_TRI   = 3'd4,
    MK_WIN   = 3'd5,
    MK_LOW   = 3'd6,
    MK_HIGH  = 3'd7
  } marker_mode_e;
endpackage

// File: rtl/swap_frame_tracker.sv
// Holds swap requests and turns them into a frame-long flag.
module swap_frame_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic swap_req,
  output logic frame_flag
);
  logic pending_q;
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      flag_q    <= 1'b0;
    end else if (frame_start) begin
      // move the held request into the flag; a coincident request waits
      flag_q    <= pending_q;
      pending_q <= swap_req;
    end else begin
      pending_q <= pending_q | swap_req;
    end
  end

  assign frame_flag = flag_q;
endmodule

// File: rtl/marker_source_mux.sv
// Picks the next marker value from the mode.
module marker_source_mux
  import swap_marker_pkg::*;
(
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              frame_start,
  input  logic              trisync,
  input  logic              win_en,
  input  logic              frame_flag,
  output logic              next_marker
);
  marker_mode_e mode;
  assign mode = marker_mode_e'(mode_sel);

  always_comb begin
    unique case (mode)
      MK_SWAP:  next_marker = win_en & frame_flag;
      MK_LINE:  next_marker = line_start;
      MK_FIELD: next_marker = field_start;
      MK_FRAME: next_marker = frame_start;
      MK_TRI:   next_marker = trisync;
      MK_WIN:   next_marker = win_en;
      MK_LOW:   next_marker = 1'b0;
      MK_HIGH:  next_marker = 1'b1;
      default:  next_marker = 1'b0;
    endcase
  end
endmodule

// File: rtl/swap_marker_top.sv
module swap_marker_top
  import swap_marker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              frame_start,
  input  logic              trisync,
  input  logic              win_en,
  input  logic              swap_req,
  output logic              marker
);
  logic frame_flag;
  logic next_marker;
  logic marker_q;

  swap_frame_tracker u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .swap_req    (swap_req),
    .frame_flag  (frame_flag)
  );

  marker_source_mux u_mux (
    .mode_sel    (mode_sel),
    .line_start  (line_start),
    .field_start (field_start),
    .frame_start (frame_start),
    .trisync     (trisync),
    .win_en      (win_en),
    .frame_flag  (frame_flag),
    .next_marker (next_marker)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) marker_q <= 1'b0;
    else        marker_q <= next_marker;
  end

  assign marker = marker_q;
endmodule

// File: rtl/swap_marker_checker.sv
module swap_marker_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_sel,
  input logic       line_start,
  input logic       frame_start,
  input logic       win_en,
  input logic       frame_flag,
  input logic       marker
);
  // R7
  const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 3'd6 |=> !marker);
  // R7
  const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 3'd7 |=> marker);
  // R6
  window_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 3'd5 |=> marker == $past(win_en));
  // R5
  line_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 3'd1 |=> marker == $past(line_start));
  // R2
  swap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd0 && !(win_en && frame_flag)) |=> !marker);
  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_flag) |-> $past(frame_start));
  // R3
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_flag) |-> $past(frame_start));
endmodule

bind swap_marker_top swap_marker_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .line_start  (line_start),
  .frame_start (frame_start),
  .win_en      (win_en),
  .frame_flag  (frame_flag),
  .marker      (marker)
);

// File: tb/swap_marker_top_bench.sv
module swap_marker_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic       line_start = 1'b0, field_start = 1'b0, frame_start = 1'b0;
  logic       trisync = 1'b0, win_en = 1'b0, swap_req = 1'b0;
  logic       marker;

  int checks = 0;
  int fails = 0;
  int pos = 0;
  int frame = 0;
  bit m_pend = 1'b0;
  bit m_flag = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swap_marker_top u_swap_marker_top (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .line_start(line_start), .field_start(field_start),
    .frame_start(frame_start), .trisync(trisync), .win_en(win_en),
    .swap_req(swap_req), .marker(marker)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pos=%0d frame=%0d actual=%0b expected=%0b", tag, pos, frame, act, exp);
    end
  endtask

  // Called at a negedge: drive one cycle of raster and compare after the edge.
  task automatic step(input logic [2:0] m, input bit sw, input string tag);
    int px = pos % 8;
    int ln = pos / 8;
    bit exp;
    mode_sel    = m;
    frame_start = (pos == 0);
    line_start  = (px == 0);
    field_start = (px == 0) && (ln == 0 || ln == 2);
    trisync     = (px == 4);
    win_en      = (px >= 2 && px <= 6 && ln >= 1);
    swap_req    = sw;
    case (m)
      3'd0: exp = win_en & m_flag;
      3'd1: exp = line_start;
      3'd2: exp = field_start;
      3'd3: exp = frame_start;
      3'd4: exp = trisync;
      3'd5: exp = win_en;
      3'd6: exp = 1'b0;
      default: exp = 1'b1;
    endcase
    @(posedge clk);
    if (frame_start) begin
      m_flag = m_pend;
      m_pend = sw;
    end else begin
      m_pend = m_pend | sw;
    end
    pos = (pos + 1) % 32;
    if (pos == 0) frame++;
    #2;
    check(marker, exp, tag);
    @(negedge clk);
  endtask

  function automatic bit swap_at(int f, int p);
    return (f == 0 && p == 10) || (f == 1 && p == 20) || (f == 4 && p == 0) ||
           (f == 7 && (p == 5 || p == 25));
  endfunction

  initial begin
    logic [7:0] lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    check(marker, 1'b0, "R1 reset value");
    rst_n = 1'b1;
    // swap-qualified mode with scripted swaps (R2 R3 R4 R9)
    for (int i = 0; i < 320; i++)
      step(3'd0, swap_at(frame, pos), "R2 R3 R4 R9 swap-qualified");
    // every other mode for two frames each (R5 R6 R7)
    for (int m = 1; m < 8; m++)
      for (int i = 0; i < 64; i++)
        step(3'(m), (pos == 13), m <= 4 ? "R5 event copy" : (m == 5 ? "R6 window copy" : "R7 constant"));
    // mode changes every cycle (R8)
    for (int i = 0; i < 320; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[2:0], (lfsr[7:5] == 3'd3), "R8 per-cycle mode change");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule